// File: doc/BRIEF.md
# Phase-Frequency Detector with Turbo Pump-Current Control

This block compares two single-cycle event pulses in the clock domain of the synthesizer logic: one pulse per edge of the divided reference and one per edge of the divided oscillator. It works as a three-state phase-frequency detector. Its two flops give source and sink commands to an external charge pump. A polarity input sets which detector flop drives the source command, so the block suits oscillators whose frequency rises with tuning voltage and oscillators whose frequency falls with it.

Each comparison ends when both flops have been set. At that point the block has counted how many cycles only one flop was high, and it compares that width against a programmable threshold. A run of narrow comparisons declares lock. A shorter run of wide comparisons withdraws it. A 3-bit current-select output tells the pump which current to use. While turbo is armed and the loop is not locked, the output asks for the large acquisition current. Otherwise it passes on the programmed 2-bit code.

Turbo disarms itself the first time lock is reached. It is armed again by a divider-reprogram pulse, or it is set explicitly by a control write. There is no streaming data path, so every pin is a plain level or a single-cycle strobe.

Top module: `pfd_cp_ctrl`

## Requirements
- R1: A high on `ref_edge` sets the up flop and a high on `vco_edge` sets the down flop at the next clock edge. In any cycle where both flops are high, both clear at the next edge, apart from an edge arriving in that same cycle, which sets its flop again. If one event leads the other by d cycles, the leading flop is high for d+1 cycles and the trailing flop for 1 cycle.
- R2: With `pol`=1, `pump_src` follows the up flop (reference leads) and `pump_snk` follows the down flop. With `pol`=0 the two are swapped.
- R3: A comparison's width is the number of cycles in which exactly one flop was high. It counts as good only when the width is strictly below `lock_thr`, so a width equal to the threshold is bad.
- R4: `lock` rises after LOCK_N (default 8) consecutive good comparisons and not before.
- R5: `lock` falls after UNLOCK_N (default 2) consecutive bad comparisons. A good comparison between two bad ones restarts that count.
- R6: `cur_sel` is 4 (acquisition current, about 2100 µA) when turbo is armed and `lock` is low. Otherwise it is {0,`cp_code`}, where codes 0, 1, 2 and 3 select 150, 210, 300 and 425 µA. It never exceeds 4.
- R7: Turbo is armed after reset and is disarmed when `lock` rises. It stays disarmed after lock is later lost, until it is re-armed.
- R8: A `div_wr` pulse re-arms turbo, clears `lock` and restarts both comparison run counts.
- R9: A `turbo_wr` pulse loads the armed state from `turbo_en`. It takes priority over a `div_wr` in the same cycle and over disarming on lock.
- R10: During and just after reset, `pump_src`, `pump_snk` and `lock` are 0 and `cur_sel` is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_edge | input | 1 | One-cycle pulse per divided reference edge |
| vco_edge | input | 1 | One-cycle pulse per divided oscillator edge |
| pol | input | 1 | Pump polarity select |
| turbo_en | input | 1 | Turbo value loaded by `turbo_wr` |
| turbo_wr | input | 1 | Control-write strobe for the turbo state |
| div_wr | input | 1 | Divider-reprogram strobe |
| cp_code | input | 2 | Programmed locked-current code |
| lock_thr | input | WW | Width threshold for a good comparison |
| pump_src | output | 1 | Charge-pump source command |
| pump_snk | output | 1 | Charge-pump sink command |
| lock | output | 1 | Lock indicator |
| cur_sel | output | 3 | Pump current select, 4 = acquisition current |

## Verification
The bench drives pairs of events in both orders, including coincident events, under both polarities. It counts the exact source and sink pulse lengths. A detector whose reset path is missing would hold both commands high, and a swapped polarity mux would exchange the two counts.

Offsets one below the threshold and exactly at it are applied, so a comparison that uses less-or-equal shows up as a lock that comes early or a lock that is never dropped. The bench counts seven and then eight good comparisons to catch a lock counter that is off by one. It breaks a run of bad comparisons with a good one to catch an unlock counter that is never restarted.

The turbo checks cover several cases:
- that turbo stays off after lock is lost;
- re-arming by a reprogram pulse;
- a write that disarms turbo in the same cycle as a reprogram pulse;
- a turbo write made while locked.

A design with the wrong priority, or one that re-arms turbo on every lock loss, shows the wrong `cur_sel`.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int CUR_W = 3;
  typedef enum logic [CUR_W-1:0] {
    CUR_150UA = 3'd0,
    CUR_210UA = 3'd1,
    CUR_300UA = 3'd2,
    CUR_425UA = 3'd3,
    CUR_TURBO = 3'd4
  } cur_sel_e;
endpackage

// File: rtl/pfd_tristate.sv
module pfd_tristate (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_edge,
  input  logic vco_edge,
  output logic up,
  output logic dn
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else if (up && dn) begin
      // reset pulse: clear both, keep any edge landing now
      up <= ref_edge;
      dn <= vco_edge;
    end else begin
      up <= up | ref_edge;
      dn <= dn | vco_edge;
    end
  end
endmodule

// File: rtl/pfd_width_meter.sv
module pfd_width_meter #(
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up,
  input  logic          dn,
  input  logic [WW-1:0] lock_thr,
  output logic          evt,
  output logic          good
);
  localparam logic [WW-1:0] WMAX = {WW{1'b1}};
  logic [WW-1:0] wcnt;

  assign evt  = up & dn;
  assign good = (wcnt < lock_thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0;
    end else if (evt) begin
      wcnt <= '0;
    end else if ((up ^ dn) && (wcnt != WMAX)) begin
      wcnt <= wcnt + 1'b1;
    end
  end
endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
  parameter int LOCK_N   = 8,
  parameter int UNLOCK_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic good,
  input  logic div_wr,
  output logic lock
);
  localparam int GW = $clog2(LOCK_N + 1);
  localparam int BW = $clog2(UNLOCK_N + 1);
  localparam logic [GW-1:0] GLAST = GW'(LOCK_N - 1);
  localparam logic [BW-1:0] BLAST = BW'(UNLOCK_N - 1);

  logic [GW-1:0] good_cnt;
  logic [BW-1:0] bad_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || div_wr) begin
      lock     <= 1'b0;
      good_cnt <= '0;
      bad_cnt  <= '0;
    end else if (evt) begin
      if (good) begin
        bad_cnt <= '0;
        if (!lock) begin
          if (good_cnt == GLAST) begin
            lock     <= 1'b1;
            good_cnt <= '0;
          end else begin
            good_cnt <= good_cnt + 1'b1;
          end
        end
      end else begin
        good_cnt <= '0;
        if (lock) begin
          if (bad_cnt == BLAST) begin
            lock    <= 1'b0;
            bad_cnt <= '0;
          end else begin
            bad_cnt <= bad_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pfd_turbo_arm.sv
module pfd_turbo_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic lock,
  input  logic div_wr,
  input  logic turbo_wr,
  input  logic turbo_en,
  output logic armed
);
  logic lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b1;
      lock_q <= 1'b0;
    end else begin
      lock_q <= lock;
      if (turbo_wr)
        armed <= turbo_en;
      else if (div_wr)
        armed <= 1'b1;
      else if (lock && !lock_q)
        armed <= 1'b0;
    end
  end
endmodule

// File: rtl/pfd_cp_ctrl.sv
module pfd_cp_ctrl #(
  parameter int WW       = 8,
  parameter int LOCK_N   = 8,
  parameter int UNLOCK_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_edge,
  input  logic          vco_edge,
  input  logic          pol,
  input  logic          turbo_en,
  input  logic          turbo_wr,
  input  logic          div_wr,
  input  logic [1:0]    cp_code,
  input  logic [WW-1:0] lock_thr,
  output logic          pump_src,
  output logic          pump_snk,
  output logic          lock,
  output logic [2:0]    cur_sel
);
  import pfd_pkg::*;

  logic up, dn, evt, good, armed;
  cur_sel_e sel;

  pfd_tristate u_det (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .vco_edge(vco_edge),
    .up(up), .dn(dn)
  );

  pfd_width_meter #(.WW(WW)) u_width (
    .clk(clk), .rst_n(rst_n), .up(up), .dn(dn), .lock_thr(lock_thr),
    .evt(evt), .good(good)
  );

  pfd_lock_det #(.LOCK_N(LOCK_N), .UNLOCK_N(UNLOCK_N)) u_lock (
    .clk(clk), .rst_n(rst_n), .evt(evt), .good(good), .div_wr(div_wr),
    .lock(lock)
  );

  pfd_turbo_arm u_turbo (
    .clk(clk), .rst_n(rst_n), .lock(lock), .div_wr(div_wr),
    .turbo_wr(turbo_wr), .turbo_en(turbo_en), .armed(armed)
  );

  assign pump_src = pol ? up : dn;
  assign pump_snk = pol ? dn : up;

  always_comb begin
    if (armed && !lock) sel = CUR_TURBO;
    else                sel = cur_sel_e'({1'b0, cp_code});
  end
  assign cur_sel = sel;
endmodule

// File: rtl/pfd_cp_ctrl_chk.sv
module pfd_cp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_edge,
  input logic       vco_edge,
  input logic       pol,
  input logic       turbo_en,
  input logic       turbo_wr,
  input logic       div_wr,
  input logic [1:0] cp_code,
  input logic       pump_src,
  input logic       pump_snk,
  input logic       lock,
  input logic [2:0] cur_sel
);
  a_r1_overlap_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_src && pump_snk && !ref_edge && !vco_edge) |=> !(pump_src || pump_snk));

  a_r2_src_origin: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pump_src) && $stable(pol)) |-> $past(pol ? ref_edge : vco_edge));

  a_r6_locked_uses_code: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> (cur_sel == {1'b0, cp_code}));

  a_r6_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
    cur_sel <= 3'd4);

  a_r8_divwr_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> !lock);

  a_r9_write_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (turbo_wr && !turbo_en) |=> (cur_sel != 3'd4));
endmodule

bind pfd_cp_ctrl pfd_cp_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .vco_edge(vco_edge),
  .pol(pol), .turbo_en(turbo_en), .turbo_wr(turbo_wr), .div_wr(div_wr),
  .cp_code(cp_code), .pump_src(pump_src), .pump_snk(pump_snk),
  .lock(lock), .cur_sel(cur_sel)
);

// File: tb/pfd_cp_ctrl_test.sv
module pfd_cp_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_edge = 1'b0, vco_edge = 1'b0, pol = 1'b1;
  logic turbo_en = 1'b0, turbo_wr = 1'b0, div_wr = 1'b0;
  logic [1:0] cp_code = 2'd2;
  logic [7:0] lock_thr = 8'd0;
  logic pump_src, pump_snk, lock;
  logic [2:0] cur_sel;
  int total = 0, bad = 0;
  int n_src, n_snk;

  always #2 clk = ~clk;

  pfd_cp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .vco_edge(vco_edge),
    .pol(pol), .turbo_en(turbo_en), .turbo_wr(turbo_wr), .div_wr(div_wr),
    .cp_code(cp_code), .lock_thr(lock_thr), .pump_src(pump_src),
    .pump_snk(pump_snk), .lock(lock), .cur_sel(cur_sel)
  );

  typedef struct packed {
    logic       pol;
    logic       ref_first;
    logic [3:0] d;
    logic [4:0] es;
    logic [4:0] ek;
  } vec_t;

  // expected lengths from R1/R2: leader d+1 cycles, trailer 1 cycle
  localparam vec_t VEC [6] = '{
    '{1'b1, 1'b1, 4'd2, 5'd3, 5'd1},
    '{1'b1, 1'b0, 4'd2, 5'd1, 5'd3},
    '{1'b0, 1'b1, 4'd2, 5'd1, 5'd3},
    '{1'b0, 1'b0, 4'd3, 5'd4, 5'd1},
    '{1'b1, 1'b1, 4'd0, 5'd1, 5'd1},
    '{1'b0, 1'b1, 4'd5, 5'd1, 5'd6}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_cmp(input logic ref_first, input int d);
    n_src = 0;
    n_snk = 0;
    for (int i = 0; i <= d + 5; i++) begin
      @(negedge clk);
      if (pump_src) n_src++;
      if (pump_snk) n_snk++;
      ref_edge = ref_first ? (i == 0) : (i == d);
      vco_edge = ref_first ? (i == d) : (i == 0);
    end
    @(negedge clk);
    ref_edge = 1'b0;
    vco_edge = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic strobe(input logic dw, input logic tw, input logic te);
    @(negedge clk);
    div_wr = dw;
    turbo_wr = tw;
    turbo_en = te;
    @(negedge clk);
    div_wr = 1'b0;
    turbo_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!pump_src && !pump_snk, "R10 pumps idle in reset", pump_src + pump_snk, 0);
    chk(!lock, "R10 lock low in reset", lock, 0);
    chk(cur_sel == 3'd4, "R10 turbo current in reset", cur_sel, 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cur_sel == 3'd4, "R10 turbo current after reset", cur_sel, 4);

    // R1/R2 table, threshold 0 so no comparison is good
    foreach (VEC[k]) begin
      pol = VEC[k].pol;
      run_cmp(VEC[k].ref_first, int'(VEC[k].d));
      chk(n_src == int'(VEC[k].es), "R1 R2 source length", n_src, VEC[k].es);
      chk(n_snk == int'(VEC[k].ek), "R1 R2 sink length", n_snk, VEC[k].ek);
      chk(!lock && cur_sel == 3'd4, "R6 acquiring uses turbo", cur_sel, 4);
    end

    // R4 lock after 8 good (d=2 < thr=3)
    pol = 1'b1;
    lock_thr = 8'd3;
    for (int j = 0; j < 7; j++) run_cmp(1'b1, 2);
    chk(!lock, "R4 no lock after 7 good", lock, 0);
    chk(cur_sel == 3'd4, "R6 turbo before lock", cur_sel, 4);
    run_cmp(1'b1, 2);
    chk(lock, "R4 lock after 8 good", lock, 1);
    chk(cur_sel == 3'd2, "R6 code after lock", cur_sel, 2);

    // R3/R5 d=3 equals thr -> bad
    run_cmp(1'b0, 3);
    chk(lock, "R5 one bad keeps lock", lock, 1);
    run_cmp(1'b1, 2);
    run_cmp(1'b1, 3);
    chk(lock, "R5 good restarts bad run", lock, 1);
    run_cmp(1'b1, 3);
    chk(!lock, "R3 R5 width equal to thr is bad, unlock", lock, 0);
    chk(cur_sel == 3'd2, "R7 turbo stays disarmed after unlock", cur_sel, 2);

    // R8 / R9
    strobe(1'b1, 1'b0, 1'b0);
    chk(cur_sel == 3'd4, "R8 div write re-arms", cur_sel, 4);
    strobe(1'b0, 1'b1, 1'b0);
    chk(cur_sel == 3'd2, "R9 write turbo off", cur_sel, 2);
    strobe(1'b1, 1'b1, 1'b0);
    chk(cur_sel == 3'd2, "R9 write beats div write", cur_sel, 2);
    strobe(1'b0, 1'b1, 1'b1);
    chk(cur_sel == 3'd4, "R9 write turbo on", cur_sel, 4);

    for (int j = 0; j < 8; j++) run_cmp(1'b0, 2);
    chk(lock, "R4 relock", lock, 1);
    cp_code = 2'd3;
    @(negedge clk);
    chk(cur_sel == 3'd3, "R6 code 3 while locked", cur_sel, 3);
    strobe(1'b0, 1'b1, 1'b1);
    chk(cur_sel == 3'd3, "R9 write while locked keeps code", cur_sel, 3);
    run_cmp(1'b1, 4);
    run_cmp(1'b1, 4);
    chk(!lock && cur_sel == 3'd4, "R9 armed write takes effect on unlock", cur_sel, 4);

    for (int j = 0; j < 8; j++) run_cmp(1'b1, 0);
    chk(lock, "R4 coincident edges lock", lock, 1);
    strobe(1'b1, 1'b0, 1'b0);
    chk(!lock, "R8 div write drops lock", lock, 0);
    chk(cur_sel == 3'd4, "R8 turbo after div write", cur_sel, 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule